// File: doc/BRIEF.md
# Crosspoint Routing Control Target

This block is the control side of a 12-input, 9-output video crosspoint switch. It is a write-only target on a two-wire serial bus (I2C style). A bus controller writes three bytes. The first is the device address byte, with the read/write bit as its low bit. The second is an internal register index. The third is the register value. The block holds one control register per output and two clamp/bias registers. From these registers it drives, for each output, an amplifier enable, a 2-bit gain code and a one-hot select of the input that feeds that output. It also drives a clamp/bias bit for each input.

SCL and SDA pass through two-flop synchronizers on a system clock that runs at least ten times faster than SCL. The byte engine is a state machine with eight states:
- `ST_IDLE`: waits for a START.
- `ST_DEV`, `ST_REG`, `ST_DAT`: each shifts in one byte.
- `ST_DEV_ACK`, `ST_REG_ACK`, `ST_DAT_ACK`: each pulls SDA low for one ACK bit.
- `ST_HOLD`: ignores everything until the next START or STOP.

The transitions are as follows:
- Any state goes to `ST_IDLE` on STOP and to `ST_DEV` on START.
- A byte state that completes eight bits moves to its ACK state on the following SCL fall.
- The exception is `ST_DEV` with a non-matching address, which returns to `ST_IDLE` instead.
- An ACK state moves to the next byte state on the SCL fall that ends the ACK bit. `ST_DAT_ACK` goes to `ST_HOLD`.

Top module: `xpt_route_ctrl`

## Requirements
- R1: The target acknowledges only the address byte `{addr_sel, 7'b0000110}`, that is 0x06 when `addr_sel` is low and 0x86 when it is high. Bit 0 of this byte is the write bit (0). A byte with bit 0 set is not acknowledged.
- R2: After an address byte that is not acknowledged, the following bytes are not acknowledged and no register changes.
- R3: After a matching address, the register index byte and the data byte are each acknowledged. The acknowledge drives `sda_oe` high only while SCL is low at its start. Any further byte before STOP is not acknowledged and is ignored.
- R4: Registers 0x01 to 0x09 belong to outputs 1 to 9. In each, bit 7 drives `out_en`, bits 6:5 drive the output's 2-bit field of `out_gain`, and bits 4:0 hold the select code.
- R5: Select code k from 1 to 12 sets bit k-1 of that output's 12-bit group `out_sel[o*12 +: 12]`, where o is the output number minus 1. Codes 0 and 13 to 31 select no input. A group never has more than one bit set.
- R6: While an output's enable bit is 0, its select group is all zero whatever code it stores. Its gain field still reflects the stored bits.
- R7: Any number of outputs may select the same input at once.
- R8: Register 0x1D bits 0 to 7 drive `in_clamp[7:0]` (inputs 1 to 8). Register 0x1E bits 0 to 3 drive `in_clamp[11:8]` (inputs 9 to 12), and its bits 7:4 are discarded. A value of 1 means clamp and 0 means bias.
- R9: Reset clears every register to 0. A data byte written to any other index (for example 0x00, 0x0A, 0x1C, 0x1F) is acknowledged and changes no output.
- R10: A register changes only in the cycle the data-byte ACK begins. A STOP or repeated START before the eighth data bit leaves every register unchanged.
- R11: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A repeated START restarts address reception from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 1 | Selects the top bit of the device address |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| out_en | output | 9 | Per-output amplifier enable |
| out_gain | output | 18 | Per-output gain code, 2 bits each (00=6 dB to 11=9 dB) |
| out_sel | output | 108 | Per-output one-hot input select, 12 bits each |
| in_clamp | output | 12 | Per-input clamp (1) or bias (0) |

## Verification
On every cycle, the assertions check three things. Each output's select group is at most one-hot and is empty while that output is disabled. The acknowledge only starts while SCL is low. No enable, gain or clamp output moves except in a cycle where the acknowledge is being driven, which ties register updates to the data-byte ACK.

Only the bench's scenarios can show the remaining behaviour. That covers the address matching under both pin settings, the exact mapping of every select code to an input, and the clamp bit positions. It also covers aborted transactions leaving state untouched and unmapped indices being dropped.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_DAT,
        ST_DAT_ACK,
        ST_HOLD
    } xpt_state_e;

    localparam logic [6:0] DEV_ADDR_LO = 7'h06;
    localparam logic [7:0] OUT_BASE    = 8'h01;
    localparam logic [7:0] CLAMP_BASE  = 8'h1D;
    localparam int         EN_BIT      = 7;
    localparam int         GAIN_LSB    = 5;
    localparam int         SEL_W       = 5;

endpackage

// File: rtl/xpt_line_sync.sv
module xpt_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [2:0] scl_q;
    logic [2:0] sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 3'b111;
            sda_q <= 3'b111;
        end else begin
            scl_q <= {scl_q[1:0], scl_i};
            sda_q <= {sda_q[1:0], sda_i};
        end
    end

    always_comb begin
        sda_s     = sda_q[1];
        scl_rise  = scl_q[1] & ~scl_q[2];
        scl_fall  = ~scl_q[1] & scl_q[2];
        start_det = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
        stop_det  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
    end
endmodule

// File: rtl/xpt_byte_fsm.sv
module xpt_byte_fsm
    import xpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] dev_match,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    output logic       sda_oe,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data
);
    xpt_state_e st, nxt;
    logic [7:0] shreg;
    logic [3:0] bit_cnt;
    logic [7:0] idx_q;
    logic       byte_end;
    logic       shifting;
    logic       acking;

    assign byte_end = scl_fall && (bit_cnt == 4'd8);
    assign shifting = (st == ST_DEV) || (st == ST_REG) || (st == ST_DAT);
    assign acking   = (st == ST_DEV_ACK) || (st == ST_REG_ACK) || (st == ST_DAT_ACK);

    always_comb begin
        nxt = st;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_DEV;
        end else begin
            unique case (st)
                ST_IDLE:    nxt = st;
                ST_HOLD:    nxt = st;
                ST_DEV:     if (byte_end) nxt = (shreg == dev_match) ? ST_DEV_ACK : ST_IDLE;
                ST_REG:     if (byte_end) nxt = ST_REG_ACK;
                ST_DAT:     if (byte_end) nxt = ST_DAT_ACK;
                ST_DEV_ACK: if (scl_fall) nxt = ST_REG;
                ST_REG_ACK: if (scl_fall) nxt = ST_DAT;
                ST_DAT_ACK: if (scl_fall) nxt = ST_HOLD;
                default:    nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
            idx_q   <= '0;
        end else if (start_det) begin
            bit_cnt <= '0;
        end else begin
            if (shifting && scl_rise && bit_cnt < 4'd8) begin
                shreg   <= {shreg[6:0], sda_s};
                bit_cnt <= bit_cnt + 4'd1;
            end
            if (acking && scl_fall) bit_cnt <= '0;
            if (st == ST_REG && byte_end) idx_q <= shreg;
        end
    end

    always_comb begin
        sda_oe  = acking;
        wr_en   = (st == ST_DAT) && byte_end && !start_det && !stop_det;
        wr_addr = idx_q;
        wr_data = shreg;
    end
endmodule

// File: rtl/xpt_route_regs.sv
module xpt_route_regs
    import xpt_pkg::*;
#(
    parameter int N_IN  = 12,
    parameter int N_OUT = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         wr_addr,
    input  logic [7:0]         wr_data,
    output logic [N_OUT-1:0]   out_en,
    output logic [2*N_OUT-1:0] out_gain,
    output logic [N_IN*N_OUT-1:0] out_sel,
    output logic [N_IN-1:0]    in_clamp
);
    localparam logic [N_IN-1:0] ONE = {{(N_IN-1){1'b0}}, 1'b1};

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        localparam logic [7:0] MY_ADDR = OUT_BASE + 8'(o);
        logic [7:0]       ctl_q;
        logic [SEL_W-1:0] code;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              ctl_q <= '0;
            else if (wr_en && wr_addr == MY_ADDR)    ctl_q <= wr_data;
        end

        assign code                   = ctl_q[SEL_W-1:0];
        assign out_en[o]              = ctl_q[EN_BIT];
        assign out_gain[2*o +: 2]     = ctl_q[GAIN_LSB +: 2];
        assign out_sel[o*N_IN +: N_IN] =
            (ctl_q[EN_BIT] && code != '0 && int'(code) <= N_IN)
                ? (ONE << (code - SEL_W'(1))) : '0;
    end

    for (genvar i = 0; i < N_IN; i++) begin : g_clamp
        localparam logic [7:0] MY_ADDR = CLAMP_BASE + 8'(i / 8);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           in_clamp[i] <= 1'b0;
            else if (wr_en && wr_addr == MY_ADDR) in_clamp[i] <= wr_data[i % 8];
        end
    end
endmodule

// File: rtl/xpt_route_ctrl.sv
module xpt_route_ctrl
    import xpt_pkg::*;
#(
    parameter int N_IN  = 12,
    parameter int N_OUT = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  addr_sel,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [N_OUT-1:0]      out_en,
    output logic [2*N_OUT-1:0]    out_gain,
    output logic [N_IN*N_OUT-1:0] out_sel,
    output logic [N_IN-1:0]       in_clamp
);
    logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       wr_en;
    logic [7:0] wr_addr, wr_data;
    logic [7:0] dev_match;

    assign dev_match = {addr_sel, DEV_ADDR_LO};

    xpt_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    xpt_byte_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .dev_match(dev_match), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .sda_oe(sda_oe), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    xpt_route_regs #(.N_IN(N_IN), .N_OUT(N_OUT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .out_en(out_en), .out_gain(out_gain),
        .out_sel(out_sel), .in_clamp(in_clamp)
    );
endmodule

// File: rtl/xpt_route_ctrl_chk.sv
module xpt_route_ctrl_chk #(
    parameter int N_IN  = 12,
    parameter int N_OUT = 9
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_i,
    input logic                  sda_oe,
    input logic [N_OUT-1:0]      out_en,
    input logic [2*N_OUT-1:0]    out_gain,
    input logic [N_IN*N_OUT-1:0] out_sel,
    input logic [N_IN-1:0]       in_clamp
);
    for (genvar o = 0; o < N_OUT; o++) begin : g_chk
        assert_sel_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(out_sel[o*N_IN +: N_IN]));
        assert_off_no_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !out_en[o] |-> (out_sel[o*N_IN +: N_IN] == '0));
    end

    assert_ack_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);
    assert_en_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_en) |-> sda_oe);
    assert_gain_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_gain) |-> sda_oe);
    assert_clamp_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(in_clamp) |-> sda_oe);
endmodule

bind xpt_route_ctrl xpt_route_ctrl_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .out_en(out_en), .out_gain(out_gain), .out_sel(out_sel), .in_clamp(in_clamp)
);

// File: tb/tb_xpt_route_ctrl.sv
module tb_xpt_route_ctrl;
    localparam int NI = 12;
    localparam int NO = 9;
    localparam int P  = 5;

    logic clk = 0, rst_n = 0, addr_sel = 0, scl = 1, sda_m = 1;
    logic sda_oe;
    logic [NO-1:0] out_en;
    logic [2*NO-1:0] out_gain;
    logic [NI*NO-1:0] out_sel;
    logic [NI-1:0] in_clamp;
    wire sda_line = sda_m & ~sda_oe;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] m_reg [NO];
    logic [NI-1:0] m_clamp;

    always #10 clk = ~clk;

    xpt_route_ctrl dut (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .out_en(out_en), .out_gain(out_gain), .out_sel(out_sel),
        .in_clamp(in_clamp)
    );

    task automatic wt(int n); repeat (n) @(negedge clk); endtask

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic i_start(); sda_m = 1; wt(P); scl = 1; wt(P); sda_m = 0; wt(P); scl = 0; wt(P); endtask
    task automatic i_stop();  sda_m = 0; wt(P); scl = 1; wt(P); sda_m = 1; wt(2*P); endtask

    task automatic send_bit(logic b);
        sda_m = b; wt(P); scl = 1; wt(2*P); scl = 0; wt(P);
    endtask

    task automatic send_byte(logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1; wt(P); scl = 1; wt(P); ack = ~sda_line; wt(P); scl = 0; wt(P);
    endtask

    task automatic xfer(logic [7:0] dv, logic [7:0] ra, logic [7:0] d, output logic [2:0] acks);
        i_start();
        send_byte(dv, acks[2]);
        send_byte(ra, acks[1]);
        send_byte(d, acks[0]);
        i_stop();
    endtask

    task automatic model_wr(logic [7:0] ra, logic [7:0] d);
        if (ra >= 8'h01 && ra <= 8'(NO)) m_reg[ra-1] = d;
        else if (ra == 8'h1D) m_clamp[7:0] = d;
        else if (ra == 8'h1E) m_clamp[11:8] = d[3:0];
    endtask

    task automatic check_all(string req);
        logic [NO-1:0] e_en;
        logic [2*NO-1:0] e_g;
        logic [NI*NO-1:0] e_s;
        e_en = '0; e_g = '0; e_s = '0;
        for (int o = 0; o < NO; o++) begin
            int code;
            code = int'(m_reg[o][4:0]);
            e_en[o] = m_reg[o][7];
            e_g[2*o +: 2] = m_reg[o][6:5];
            if (m_reg[o][7] && code >= 1 && code <= NI) e_s[o*NI + code - 1] = 1'b1;
        end
        check({req, " en"}, 128'(out_en), 128'(e_en));
        check({req, " gain"}, 128'(out_gain), 128'(e_g));
        check({req, " sel"}, 128'(out_sel), 128'(e_s));
        check({req, " clamp"}, 128'(in_clamp), 128'(m_clamp));
    endtask

    task automatic good_wr(string req, logic [7:0] ra, logic [7:0] d);
        logic [2:0] a;
        xfer({addr_sel, 7'h06}, ra, d, a);
        check({req, " ack"}, 128'(a), 128'(3'b111));
        model_wr(ra, d);
        check_all(req);
    endtask

    initial begin
        logic [2:0] a;
        logic ak;
        for (int o = 0; o < NO; o++) m_reg[o] = '0;
        m_clamp = '0;
        wt(4); rst_n = 1; wt(4);
        check_all("R9 reset");

        good_wr("R1 R4 R5", 8'h01, 8'h8C);
        good_wr("R4 gain", 8'h09, 8'hE3);

        xfer(8'h86, 8'h02, 8'h81, a);
        check("R2 wrong addr ack", 128'(a), 128'(3'b000));
        check_all("R2 wrong addr");
        xfer(8'h07, 8'h02, 8'h81, a);
        check("R1 read bit ack", 128'(a), 128'(3'b000));
        check_all("R1 read bit");
        addr_sel = 1; wt(4);
        good_wr("R1 high addr", 8'h02, 8'hA5);
        xfer(8'h06, 8'h03, 8'h81, a);
        check("R2 low addr with pin high", 128'(a), 128'(3'b000));
        check_all("R2 pin high");
        addr_sel = 0; wt(4);

        for (int c = 0; c < 32; c++) begin
            good_wr("R5 sweep", 8'((c % NO) + 1), {1'b1, 2'(c >> 1), 5'(c)});
            good_wr("R6 sweep", 8'(((c + 4) % NO) + 1), {1'b0, 2'(c), 5'(c)});
        end

        for (int o = 0; o < NO; o++) good_wr("R7 fanout", 8'(o + 1), 8'h85);

        good_wr("R8 clamp lo", 8'h1D, 8'hA5);
        good_wr("R8 clamp hi", 8'h1E, 8'hF6);
        good_wr("R8 clamp lo2", 8'h1D, 8'h5A);

        good_wr("R9 unmapped 00", 8'h00, 8'hFF);
        good_wr("R9 unmapped 0A", 8'h0A, 8'hFF);
        good_wr("R9 unmapped 1C", 8'h1C, 8'hFF);
        good_wr("R9 unmapped 1F", 8'h1F, 8'hFF);

        i_start();
        send_byte(8'h06, ak);
        send_byte(8'h03, ak);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        i_stop();
        check_all("R10 stop abort");

        i_start();
        send_byte(8'h06, ak);
        send_byte(8'h04, ak);
        for (int i = 0; i < 7; i++) send_bit(1'b0);
        i_start();
        send_byte(8'h06, a[2]);
        send_byte(8'h05, a[1]);
        send_byte(8'hC7, a[0]);
        i_stop();
        check("R11 restart ack", 128'(a), 128'(3'b111));
        model_wr(8'h05, 8'hC7);
        check_all("R10 R11 restart");

        i_start();
        send_byte(8'h06, ak);
        send_byte(8'h06, ak);
        send_byte(8'h8B, ak);
        send_byte(8'h81, ak);
        i_stop();
        check("R3 extra byte nack", 128'(ak), 128'(1'b0));
        model_wr(8'h06, 8'h8B);
        check_all("R3 extra byte");

        good_wr("R6 disable keeps gain", 8'h06, 8'h6B);

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule